// File: doc/BRIEF.md
# Instruction Trace View Filter

This block decides in every cycle whether the instruction now retiring may be traced. A 32-bit control word, written and read over a one-register bus, holds the filter settings. Three terms are combined into the single `trace_en` output. The first is a per-level, per-security-state exclude flag. The second is a resource event, taken either from one selector in a bank or from a Boolean combination of a selector pair. The third is a start/stop status kept by a small state machine.

The start/stop machine has two states, `SS_STOPPED` and `SS_STARTED`. It has these transitions:
- **Seed**: a bus write loads bit 9 and has the highest priority.
- **Start**: a `start_pt` pulse without `stop_pt` moves `SS_STOPPED` to `SS_STARTED`.
- **Stop**: a `stop_pt` pulse moves `SS_STARTED` to `SS_STOPPED`, and it wins over a simultaneous start.
- **Hold**: with no stimulus the state is kept.

When the block is built without comparators (`HAS_CMP = 0`), the machine is replaced by a constant "started". The block also issues one-cycle forced-trace requests for core resets and system errors.

Top module: `tvf_top`

## Requirements
- R1: After reset every writable field is 0, so a read returns 0x00000000. With `HAS_CMP = 0` a read returns 0x00000200.
- R2: Only the bits in mask 0x007F0E9F are writable. All other bits read 0 and ignore writes.
- R3: A request made while `acc_allow` = 0, `os_lock` = 1 or `core_pwr_on` = 0 responds one cycle later with `bus_resp_err` = 1 and `bus_rdata` = 0. Such a write changes no state.
- R4: Bits 22/21/20 exclude non-secure levels 2/1/0, and bits 19/18/17/16 exclude secure levels 3/2/1/0. A 1 forces `trace_en` low at that level (`cur_ns` = 1 means non-secure).
- R5: A non-secure level 3 is never traced.
- R6: When bit 7 = 0, the event is `rs_out[bits 4:0]`.
- R7: When bit 7 = 1, bits 3:0 select pair p, with A = `rs_out[2p]` and B = `rs_out[2p+1]`. `pair_func` selects the function: 00 gives A&B, 01 gives A|B, 10 gives A&~B, 11 gives A^B.
- R8: A write with bit 7 = 1 stores bit 4 as 0, and that bit reads back as 0.
- R9: The start/stop status reads in bit 9 (1 = started). A bus write seeds it. `start_pt` starts it and `stop_pt` stops it. Stop wins over start, and a write wins over both. Each change shows from the next cycle.
- R10: `trace_en` = NOT exclude AND event AND started. It is combinational in the current level, state and `rs_out`.
- R11: `force_rst_trace` and `force_serr_trace` pulse high for exactly the cycle after `pe_rst_evt` or `serr_evt` when the enable bit is set: bit 10 for reset and bit 11 for system error. This holds whatever the filter result is.
- R12: With `HAS_CMP = 0`, bit 9 always reads 1 and cannot be written, and the filter behaves as permanently started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data |
| bus_resp_vld | output | 1 | Response valid, one cycle after the request |
| bus_resp_err | output | 1 | Access refused |
| bus_rdata | output | 32 | Read data (0 on writes and errors) |
| acc_allow | input | 1 | External access permitted |
| os_lock | input | 1 | OS lock set |
| core_pwr_on | input | 1 | Core power domain on |
| cur_el | input | 2 | Exception level of the retiring instruction |
| cur_ns | input | 1 | 1 = non-secure state |
| rs_out | input | NUM_RS | Resource selector outputs |
| pair_func | input | 2 | Boolean function for pair mode |
| start_pt | input | 1 | Start point hit |
| stop_pt | input | 1 | Stop point hit |
| pe_rst_evt | input | 1 | Core reset event |
| serr_evt | input | 1 | System error event |
| trace_en | output | 1 | Instruction trace enabled |
| force_rst_trace | output | 1 | Forced trace request for reset |
| force_serr_trace | output | 1 | Forced trace request for system error |

## Verification
The bench drives every level and state against a mix of exclude flags. A swapped bit index would then trace the wrong level, and a design that traced non-secure level 3 would show up. It runs each pair function over all four A/B values and sets bit 4 together with pair mode, so a design that kept bit 4 would pick the wrong pair. It pulses start and stop together, and pulses stop together with a seeding write, to catch a wrong priority. It refuses accesses through each of the three gates, and checks that a refused write leaves the state unchanged. A second instance without comparators catches a writable status bit.

// File: rtl/tvf_pkg.sv
package tvf_pkg;
    localparam int REG_W = 32;
    localparam int SEL_W = 5;
    localparam logic [REG_W-1:0] WR_MASK = 32'h007F_0E9F;

    typedef enum logic [1:0] {
        PF_AND  = 2'b00,
        PF_OR   = 2'b01,
        PF_ANDN = 2'b10,
        PF_XOR  = 2'b11
    } pair_fn_e;

    typedef enum logic {
        SS_STOPPED = 1'b0,
        SS_STARTED = 1'b1
    } ss_state_e;

    typedef struct packed {
        logic [2:0]       excl_ns;
        logic [3:0]       excl_s;
        logic             force_serr;
        logic             force_rst;
        logic             pair_mode;
        logic [SEL_W-1:0] sel;
    } ctl_fields_t;
endpackage

// File: rtl/tvf_regfile.sv
module tvf_regfile
    import tvf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic             acc_allow,
    input  logic             os_lock,
    input  logic             core_pwr_on,
    input  logic             ss_started,
    output logic             bus_resp_vld,
    output logic             bus_resp_err,
    output logic [REG_W-1:0] bus_rdata,
    output ctl_fields_t      ctl,
    output logic             ss_wr,
    output logic             ss_wval
);
    logic             acc_ok;
    logic             wr_ok;
    logic [REG_W-1:0] rd_word;
    logic             unused_wd;

    assign acc_ok    = acc_allow & ~os_lock & core_pwr_on;
    assign wr_ok     = bus_req & bus_we & acc_ok;
    assign ss_wr     = wr_ok;
    assign ss_wval   = bus_wdata[9];
    assign unused_wd = ^{bus_wdata[31:23], bus_wdata[15:12], bus_wdata[8], bus_wdata[6:5]};

    always_comb begin
        rd_word        = '0;
        rd_word[22:20] = ctl.excl_ns;
        rd_word[19:16] = ctl.excl_s;
        rd_word[11]    = ctl.force_serr;
        rd_word[10]    = ctl.force_rst;
        rd_word[9]     = ss_started;
        rd_word[7]     = ctl.pair_mode;
        rd_word[4:0]   = ctl.sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_ok) begin
            ctl.excl_ns    <= bus_wdata[22:20];
            ctl.excl_s     <= bus_wdata[19:16];
            ctl.force_serr <= bus_wdata[11];
            ctl.force_rst  <= bus_wdata[10];
            ctl.pair_mode  <= bus_wdata[7];
            ctl.sel        <= {bus_wdata[4] & ~bus_wdata[7], bus_wdata[3:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_resp_vld <= 1'b0;
            bus_resp_err <= 1'b0;
            bus_rdata    <= '0;
        end else begin
            bus_resp_vld <= bus_req;
            bus_resp_err <= bus_req & ~acc_ok;
            bus_rdata    <= (bus_req & ~bus_we & acc_ok) ? rd_word : '0;
        end
    end

    a_r3_refused_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !acc_ok) |=> $stable(ctl));
    a_r2_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_resp_vld |-> ((bus_rdata & ~WR_MASK) == '0));
    a_r8_pair_bit4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pair_mode |-> !ctl.sel[4]);
endmodule

// File: rtl/tvf_event_sel.sv
module tvf_event_sel
    import tvf_pkg::*;
#(
    parameter int NUM_RS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_RS-1:0] rs_out,
    input  logic             pair_mode,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       pair_func,
    output logic             evt
);
    localparam int NPAIR = NUM_RS / 2;

    logic [NPAIR-1:0] pair_res;
    logic             single_res;
    logic             pair_pick;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        always_comb begin
            unique case (pair_fn_e'(pair_func))
                PF_AND:  pair_res[p] = rs_out[2*p] &  rs_out[2*p+1];
                PF_OR:   pair_res[p] = rs_out[2*p] |  rs_out[2*p+1];
                PF_ANDN: pair_res[p] = rs_out[2*p] & ~rs_out[2*p+1];
                PF_XOR:  pair_res[p] = rs_out[2*p] ^  rs_out[2*p+1];
                default: pair_res[p] = 1'b0;
            endcase
        end
    end

    always_comb begin
        single_res = (int'(sel) < NUM_RS) ? rs_out[sel] : 1'b0;
        pair_pick  = (int'(sel[3:0]) < NPAIR) ? pair_res[sel[3:0]] : 1'b0;
        evt        = pair_mode ? pair_pick : single_res;
    end

    a_r6_single_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_mode && evt) |-> (rs_out != '0));
    a_r7_and_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_mode && pair_func == 2'b00 && evt) |-> ($countones(rs_out) >= 2));
endmodule

// File: rtl/tvf_startstop.sv
module tvf_startstop
    import tvf_pkg::*;
#(
    parameter bit HAS_CMP = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_wr,
    input  logic sw_val,
    input  logic start_pt,
    input  logic stop_pt,
    output logic started
);
    if (HAS_CMP) begin : g_fsm
        ss_state_e st_q, st_d;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= SS_STOPPED;
            else        st_q <= st_d;
        end

        always_comb begin
            st_d = st_q;
            if (sw_wr) begin
                st_d = sw_val ? SS_STARTED : SS_STOPPED;
            end else begin
                unique case (st_q)
                    SS_STOPPED: if (start_pt && !stop_pt) st_d = SS_STARTED;
                    SS_STARTED: if (stop_pt)              st_d = SS_STOPPED;
                    default:    st_d = SS_STOPPED;
                endcase
            end
        end

        always_comb begin
            started = (st_q == SS_STARTED);
        end

        a_r9_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (!sw_wr && stop_pt) |=> !started);
        a_r9_start_hit: assert property (@(posedge clk) disable iff (!rst_n)
            (!sw_wr && start_pt && !stop_pt) |=> started);
        a_r9_seed_write: assert property (@(posedge clk) disable iff (!rst_n)
            sw_wr |=> (started == $past(sw_val)));
    end else begin : g_fixed
        logic unused_ss;
        assign unused_ss = ^{clk, rst_n, sw_wr, sw_val, start_pt, stop_pt};
        assign started   = 1'b1;
    end
endmodule

// File: rtl/tvf_top.sv
module tvf_top
    import tvf_pkg::*;
#(
    parameter int NUM_RS  = 32,
    parameter bit HAS_CMP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic              bus_resp_vld,
    output logic              bus_resp_err,
    output logic [31:0]       bus_rdata,
    input  logic              acc_allow,
    input  logic              os_lock,
    input  logic              core_pwr_on,
    input  logic [1:0]        cur_el,
    input  logic              cur_ns,
    input  logic [NUM_RS-1:0] rs_out,
    input  logic [1:0]        pair_func,
    input  logic              start_pt,
    input  logic              stop_pt,
    input  logic              pe_rst_evt,
    input  logic              serr_evt,
    output logic              trace_en,
    output logic              force_rst_trace,
    output logic              force_serr_trace
);
    ctl_fields_t ctl;
    logic        ss_started;
    logic        ss_wr;
    logic        ss_wval;
    logic        evt;
    logic        excluded;

    tvf_regfile u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_req      (bus_req),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .acc_allow    (acc_allow),
        .os_lock      (os_lock),
        .core_pwr_on  (core_pwr_on),
        .ss_started   (ss_started),
        .bus_resp_vld (bus_resp_vld),
        .bus_resp_err (bus_resp_err),
        .bus_rdata    (bus_rdata),
        .ctl          (ctl),
        .ss_wr        (ss_wr),
        .ss_wval      (ss_wval)
    );

    tvf_startstop #(.HAS_CMP(HAS_CMP)) u_ss (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_wr    (ss_wr),
        .sw_val   (ss_wval),
        .start_pt (start_pt),
        .stop_pt  (stop_pt),
        .started  (ss_started)
    );

    tvf_event_sel #(.NUM_RS(NUM_RS)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .rs_out    (rs_out),
        .pair_mode (ctl.pair_mode),
        .sel       (ctl.sel),
        .pair_func (pair_func),
        .evt       (evt)
    );

    always_comb begin
        if (cur_ns) begin
            unique case (cur_el)
                2'd0:    excluded = ctl.excl_ns[0];
                2'd1:    excluded = ctl.excl_ns[1];
                2'd2:    excluded = ctl.excl_ns[2];
                default: excluded = 1'b1;
            endcase
        end else begin
            excluded = ctl.excl_s[cur_el];
        end
        trace_en = ~excluded & evt & ss_started;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            force_rst_trace  <= 1'b0;
            force_serr_trace <= 1'b0;
        end else begin
            force_rst_trace  <= pe_rst_evt & ctl.force_rst;
            force_serr_trace <= serr_evt & ctl.force_serr;
        end
    end

    a_r10_needs_started: assert property (@(posedge clk) disable iff (!rst_n)
        trace_en |-> ss_started);
    a_r5_ns_level3_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ns && cur_el == 2'd3) |-> !trace_en);
    a_r11_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
        force_rst_trace |-> $past(pe_rst_evt));
    a_r11_serr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        force_serr_trace |-> $past(serr_evt));
endmodule

// File: tb/tvf_top_tb_top.sv
module tvf_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        acc_allow = 1'b1, os_lock = 1'b0, core_pwr_on = 1'b1;
    logic [1:0]  cur_el = '0;
    logic        cur_ns = 1'b0;
    logic [31:0] rs_out = '0;
    logic [1:0]  pair_func = '0;
    logic        start_pt = 1'b0, stop_pt = 1'b0, pe_rst_evt = 1'b0, serr_evt = 1'b0;

    logic        resp_vld, resp_err, trace_en, f_rst, f_serr;
    logic [31:0] rdata;
    logic        nc_vld, nc_err, nc_te, nc_frst, nc_fserr;
    logic [31:0] nc_rdata;

    always #5 clk = ~clk;

    tvf_top #(.NUM_RS(32), .HAS_CMP(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_resp_vld(resp_vld), .bus_resp_err(resp_err), .bus_rdata(rdata),
        .acc_allow(acc_allow), .os_lock(os_lock), .core_pwr_on(core_pwr_on),
        .cur_el(cur_el), .cur_ns(cur_ns), .rs_out(rs_out), .pair_func(pair_func),
        .start_pt(start_pt), .stop_pt(stop_pt), .pe_rst_evt(pe_rst_evt), .serr_evt(serr_evt),
        .trace_en(trace_en), .force_rst_trace(f_rst), .force_serr_trace(f_serr));

    tvf_top #(.NUM_RS(32), .HAS_CMP(1'b0)) dut_nc_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_resp_vld(nc_vld), .bus_resp_err(nc_err), .bus_rdata(nc_rdata),
        .acc_allow(acc_allow), .os_lock(os_lock), .core_pwr_on(core_pwr_on),
        .cur_el(cur_el), .cur_ns(cur_ns), .rs_out(rs_out), .pair_func(pair_func),
        .start_pt(start_pt), .stop_pt(stop_pt), .pe_rst_evt(pe_rst_evt), .serr_evt(serr_evt),
        .trace_en(nc_te), .force_rst_trace(nc_frst), .force_serr_trace(nc_fserr));

    int tests = 0, fails = 0;
    bit done = 0;

    typedef struct { logic err; logic [31:0] data; string tag; } exp_t;
    exp_t sbq[$];
    exp_t cur;

    logic [31:0] m_reg = '0;
    logic        m_started = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic m_event(logic [31:0] r, logic [31:0] rs, logic [1:0] f);
        logic a, b;
        if (!r[7]) return rs[r[4:0]];
        a = rs[{r[3:0], 1'b0}];
        b = rs[{r[3:0], 1'b1}];
        case (f)
            2'b00:   return a & b;
            2'b01:   return a | b;
            2'b10:   return a & ~b;
            default: return a ^ b;
        endcase
    endfunction

    function automatic logic m_te(logic st);
        logic ex;
        if (cur_ns) ex = (cur_el == 2'd3) ? 1'b1 : m_reg[20 + int'(cur_el)];
        else        ex = m_reg[16 + int'(cur_el)];
        return !ex && m_event(m_reg, rs_out, pair_func) && st;
    endfunction

    // Monitor: pops expected bus responses as the design produces them.
    always @(negedge clk) begin
        if (rst_n && resp_vld) begin
            if (sbq.size() == 0) begin
                tests++; fails++;
                $display("FAIL R3 unexpected response actual=1 expected=0");
            end else begin
                cur = sbq.pop_front();
                chk({cur.tag, " err"},  {31'b0, resp_err}, {31'b0, cur.err});
                chk({cur.tag, " data"}, rdata, cur.data);
            end
        end
    end

    // Driver: issues one access, pushes the expected response, updates the model.
    task automatic bus_op(input logic we, input logic [31:0] wd, input logic stp, input string tag);
        logic  ok;
        exp_t  e;
        logic [31:0] nc_exp;
        @(negedge clk);
        ok = acc_allow && !os_lock && core_pwr_on;
        bus_req = 1'b1; bus_we = we; bus_wdata = wd; stop_pt = stp;
        e.err  = !ok;
        e.data = (!ok || we) ? 32'h0 : (m_reg | ({31'b0, m_started} << 9));
        e.tag  = tag;
        nc_exp = (!ok || we) ? 32'h0 : (m_reg | 32'h200);
        sbq.push_back(e);
        if (we && ok) begin
            m_reg = wd & 32'h007F_0C9F;
            if (wd[7]) m_reg[4] = 1'b0;
            m_started = wd[9];
        end else if (stp) begin
            m_started = 1'b0;
        end
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; stop_pt = 1'b0;
        chk({tag, " nc"}, nc_rdata, nc_exp);
    endtask

    task automatic ss_pulse(input logic st, input logic sp);
        @(negedge clk);
        start_pt = st; stop_pt = sp;
        if (sp) m_started = 1'b0;
        else if (st) m_started = 1'b1;
        @(negedge clk);
        start_pt = 1'b0; stop_pt = 1'b0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_op(1'b0, 0, 1'b0, "R1 reset read");
        #1 chk("R1 trace_en after reset", {31'b0, trace_en}, 0);

        // R2 / R8: all ones; pair mode clears bit 4
        bus_op(1'b1, 32'hFFFF_FFFF, 1'b0, "R2 write ones");
        bus_op(1'b0, 0, 1'b0, "R2 R8 read ones");
        bus_op(1'b1, 32'h0000_0215, 1'b0, "R2 write single");
        bus_op(1'b0, 0, 1'b0, "R2 read single");

        // R3: each gate refuses, state unchanged
        os_lock = 1'b1;      bus_op(1'b1, 32'h0, 1'b0, "R3 locked write");
        os_lock = 1'b0; acc_allow = 1'b0; bus_op(1'b0, 0, 1'b0, "R3 disallowed read");
        acc_allow = 1'b1; core_pwr_on = 1'b0; bus_op(1'b1, 32'h0, 1'b0, "R3 powered off write");
        core_pwr_on = 1'b1;  bus_op(1'b0, 0, 1'b0, "R3 read unchanged");

        // R4 / R5: exclude map, single selector 3, started
        bus_op(1'b1, 32'h0025_0203, 1'b0, "R4 write excludes");
        rs_out = 32'h8;
        for (int ns = 0; ns < 2; ns++) begin
            for (int el = 0; el < 4; el++) begin
                @(negedge clk); cur_ns = ns[0]; cur_el = el[1:0]; #1;
                chk($sformatf("R4 R5 ns=%0d el=%0d", ns, el), {31'b0, trace_en}, {31'b0, m_te(m_started)});
            end
        end

        // R6: single selection over several sources
        bus_op(1'b1, 32'h0000_0200, 1'b0, "R6 open filter");
        cur_ns = 1'b0; cur_el = 2'd1;
        for (int k = 0; k < 32; k += 7) begin
            bus_op(1'b1, 32'h0000_0200 | k, 1'b0, "R6 select");
            for (int j = 0; j < 32; j += 5) begin
                @(negedge clk); rs_out = 32'h1 << j; #1;
                chk($sformatf("R6 sel=%0d src=%0d", k, j), {31'b0, trace_en}, {31'b0, m_te(m_started)});
            end
        end

        // R7 / R8: pair mode, bit 4 written as 1 -> pair 5
        bus_op(1'b1, 32'h0000_0295, 1'b0, "R8 pair write");
        bus_op(1'b0, 0, 1'b0, "R8 pair read");
        for (int f = 0; f < 4; f++) begin
            for (int ab = 0; ab < 4; ab++) begin
                @(negedge clk); pair_func = f[1:0]; rs_out = 32'(ab) << 10; #1;
                chk($sformatf("R7 func=%0d ab=%0d", f, ab), {31'b0, trace_en}, {31'b0, m_te(m_started)});
            end
            @(negedge clk); rs_out = 32'h3 << 26; #1;
            chk($sformatf("R8 pair21 ignored func=%0d", f), {31'b0, trace_en}, 0);
        end

        // R9 / R10 / R12: start/stop machine
        bus_op(1'b1, 32'h0000_0000, 1'b0, "R9 seed stopped");
        @(negedge clk); rs_out = 32'h1; #1;
        chk("R10 stopped blocks", {31'b0, trace_en}, 0);
        chk("R12 nc always started", {31'b0, nc_te}, 1);
        bus_op(1'b0, 0, 1'b0, "R9 R12 read stopped");
        ss_pulse(1'b1, 1'b0);
        chk("R9 start hit", {31'b0, trace_en}, 1);
        ss_pulse(1'b1, 1'b1);
        chk("R9 stop wins", {31'b0, trace_en}, 0);
        ss_pulse(1'b1, 1'b1);
        chk("R9 both while stopped", {31'b0, trace_en}, 0);
        ss_pulse(1'b1, 1'b0);
        bus_op(1'b1, 32'h0000_0200, 1'b1, "R9 write with stop");
        #1 chk("R9 write wins", {31'b0, trace_en}, 1);
        @(negedge clk); rs_out = 32'h0; #1;
        chk("R10 no event", {31'b0, trace_en}, 0);

        // R11: forced requests with filter closed
        bus_op(1'b1, 32'h0001_0C00, 1'b0, "R11 enable forces");
        cur_ns = 1'b0; cur_el = 2'd0;
        @(negedge clk); pe_rst_evt = 1'b1;
        @(negedge clk); pe_rst_evt = 1'b0; #1;
        chk("R11 reset force pulse", {30'b0, f_rst, f_serr}, 32'h2);
        @(negedge clk); #1;
        chk("R11 reset force one cycle", {31'b0, f_rst}, 0);
        @(negedge clk); serr_evt = 1'b1;
        @(negedge clk); serr_evt = 1'b0; #1;
        chk("R11 serr force pulse", {30'b0, f_rst, f_serr}, 32'h1);
        chk("R11 nc serr force", {31'b0, nc_fserr}, 1);
        bus_op(1'b1, 32'h0000_0200, 1'b0, "R11 disable forces");
        @(negedge clk); pe_rst_evt = 1'b1; serr_evt = 1'b1;
        @(negedge clk); pe_rst_evt = 1'b0; serr_evt = 1'b0; #1;
        chk("R11 disabled no force", {30'b0, f_rst, f_serr}, 0);

        repeat (3) @(negedge clk);
        chk("R3 scoreboard drained", sbq.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule